// File: doc/BRIEF.md
# Runtime-Split SIMD Adder

This block is a single 32-bit adder whose carry chain can be cut between any two adjacent bytes while it runs. A 3-bit split mask picks one of eight lane layouts. The layouts range from one 32-bit sum, through mixes such as a low 8-bit lane under a 24-bit lane, to four separate 8-bit sums. Each lane adds its own slice of the two operands together with a shared carry-in.

Separate scalar and vector adders are not used. The design widens both operands by one slot at each byte seam and uses the slot values to pass a carry across a joined seam or to stop it at a split seam. It then performs one wide addition and extracts the per-lane sums from the non-slot positions. A per-byte carry vector reports the carry that leaves the top of every lane. An output register stage can be selected by a parameter.

Top module: `simd_split_adder`

## Requirements
- R1: With split mask 000, the block forms one 32-bit lane. sum_o equals (a_i + b_i + cin_i) modulo 2^32, and cout_o[3] is bit 32 of that sum.
- R2: Mask bit k (k = 0..2) sits between byte k (bits 8k+7..8k) and byte k+1. A 1 places a lane boundary there, and a 0 joins the two bytes into one lane. Every lane's sum bits equal (lane of a_i + lane of b_i + cin_i) modulo 2^(lane width).
- R3: No carry crosses a split seam. For example, with mask 111, adding 0xFF and 0x01 in one byte leaves the byte above it at exactly its own a+b+cin.
- R4: cin_i is added at the lowest byte of every lane, and not only at bit 0.
- R5: For k < 3, cout_o[k] holds the carry out of the lane that ends at byte k when mask bit k is 1, and reads 0 when mask bit k is 0. cout_o[3] always holds the carry out of the top lane.
- R6: All eight mask values work, including the mixed layouts 001 (8-bit lane under a 24-bit lane), 100 (24-bit lane under an 8-bit lane), 011, 101 and 110.
- R7: With REG_OUT=1 (the default), sum_o and cout_o show the result of the inputs present at one rising clock edge from just after that edge onward. While rst_n is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset; clears the output stage |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cut_i | input | 3 | Split mask; bit k = 1 places a lane boundary above byte k |
| cin_i | input | 1 | Carry-in applied to the bottom of every lane |
| sum_o | output | 32 | Per-lane sums packed in place |
| cout_o | output | 4 | Per-byte lane carry-out, 0 inside a joined lane |

## Verification
With the default output stage, each sum and carry vector is due on the first rising edge after its operands are applied. The driver changes the inputs on a falling edge and queues the expected result. The monitor compares sum_o and cout_o 2 ns after the next rising edge, so every queued item meets exactly the edge that captured its operands. The bench's expected values come from a lane-by-lane model that walks the mask, finds each lane's bounds and adds it in a wide integer. This model never builds the widened operands.

// File: rtl/simd_split_pkg.sv
package simd_split_pkg;
  localparam int unsigned SEG_W_DEF   = 8;
  localparam int unsigned NUM_SEG_DEF = 4;

  // Position of segment k's lowest bit inside the widened operand
  function automatic int unsigned wide_base(input int unsigned k, input int unsigned seg_w);
    return k * (seg_w + 1);
  endfunction

  // Position of the seam slot sitting above segment k
  function automatic int unsigned slot_pos(input int unsigned k, input int unsigned seg_w);
    return k * (seg_w + 1) + seg_w;
  endfunction
endpackage

// File: rtl/simd_split_widen.sv
module simd_split_widen
  import simd_split_pkg::*;
#(
  parameter int unsigned SEG_W   = SEG_W_DEF,
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  localparam int unsigned DATA_W = SEG_W * NUM_SEG,
  localparam int unsigned WIDE_W = DATA_W + NUM_SEG - 1
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [NUM_SEG-2:0] cut_i,
  input  logic               cin_i,
  output logic [WIDE_W-1:0]  a_wide_o,
  output logic [WIDE_W-1:0]  b_wide_o
);
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    assign a_wide_o[wide_base(k, SEG_W) +: SEG_W] = a_i[k*SEG_W +: SEG_W];
    assign b_wide_o[wide_base(k, SEG_W) +: SEG_W] = b_i[k*SEG_W +: SEG_W];
    if (k < NUM_SEG - 1) begin : g_slot
      // joined seam: 0 + 1 propagates an incoming carry
      // split seam : 0 + 0 absorbs it; 1 + 1 absorbs it and launches cin upward
      assign a_wide_o[slot_pos(k, SEG_W)] = cut_i[k] & cin_i;
      assign b_wide_o[slot_pos(k, SEG_W)] = ~cut_i[k] | cin_i;
    end
  end
endmodule

// File: rtl/simd_split_core.sv
module simd_split_core #(
  parameter int unsigned WIDE_W = 35
) (
  input  logic [WIDE_W-1:0] a_wide_i,
  input  logic [WIDE_W-1:0] b_wide_i,
  input  logic              cin_i,
  output logic [WIDE_W-1:0] s_wide_o,
  output logic              top_co_o
);
  logic [WIDE_W:0] total;
  assign total    = {1'b0, a_wide_i} + {1'b0, b_wide_i} + {{WIDE_W{1'b0}}, cin_i};
  assign s_wide_o = total[WIDE_W-1:0];
  assign top_co_o = total[WIDE_W];
endmodule

// File: rtl/simd_split_gather.sv
module simd_split_gather
  import simd_split_pkg::*;
#(
  parameter int unsigned SEG_W   = SEG_W_DEF,
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  localparam int unsigned DATA_W = SEG_W * NUM_SEG,
  localparam int unsigned WIDE_W = DATA_W + NUM_SEG - 1
) (
  input  logic [WIDE_W-1:0]  s_wide_i,
  input  logic               top_co_i,
  input  logic [NUM_SEG-2:0] cut_i,
  output logic [DATA_W-1:0]  sum_o,
  output logic [NUM_SEG-1:0] cout_o
);
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    assign sum_o[k*SEG_W +: SEG_W] = s_wide_i[wide_base(k, SEG_W) +: SEG_W];
    if (k < NUM_SEG - 1) begin : g_mid
      assign cout_o[k] = cut_i[k] & s_wide_i[slot_pos(k, SEG_W)];
    end else begin : g_top
      assign cout_o[k] = top_co_i;
    end
  end
endmodule

// File: rtl/simd_split_adder.sv
module simd_split_adder
  import simd_split_pkg::*;
#(
  parameter int unsigned SEG_W   = SEG_W_DEF,
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned DATA_W = SEG_W * NUM_SEG,
  localparam int unsigned WIDE_W = DATA_W + NUM_SEG - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [NUM_SEG-2:0] cut_i,
  input  logic               cin_i,
  output logic [DATA_W-1:0]  sum_o,
  output logic [NUM_SEG-1:0] cout_o
);
  logic [WIDE_W-1:0]  a_wide, b_wide, s_wide;
  logic               top_co;
  logic [DATA_W-1:0]  sum_c;
  logic [NUM_SEG-1:0] cout_c;

  simd_split_widen #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_widen (
    .a_i(a_i), .b_i(b_i), .cut_i(cut_i), .cin_i(cin_i),
    .a_wide_o(a_wide), .b_wide_o(b_wide)
  );

  simd_split_core #(.WIDE_W(WIDE_W)) u_core (
    .a_wide_i(a_wide), .b_wide_i(b_wide), .cin_i(cin_i),
    .s_wide_o(s_wide), .top_co_o(top_co)
  );

  simd_split_gather #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_gather (
    .s_wide_i(s_wide), .top_co_i(top_co), .cut_i(cut_i),
    .sum_o(sum_c), .cout_o(cout_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_o  <= '0;
        cout_o <= '0;
      end else begin
        sum_o  <= sum_c;
        cout_o <= cout_c;
      end
    end

    assert_stage_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (sum_o == $past(sum_c) && cout_o == $past(cout_c)));
  end else begin : g_comb
    assign sum_o  = sum_c;
    assign cout_o = cout_c;
  end

  // Whole-word layout against a plain wide add
  assert_full_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_i == '0) |->
      ({cout_c[NUM_SEG-1], sum_c} ==
       ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i})));

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_chk
    logic lo_edge, hi_edge;
    if (k == 0) begin : g_lo0
      assign lo_edge = 1'b1;
    end else begin : g_lon
      assign lo_edge = cut_i[k-1];
    end
    if (k == NUM_SEG - 1) begin : g_hitop
      assign hi_edge = 1'b1;
    end else begin : g_hin
      assign hi_edge = cut_i[k];
      assert_inner_cout_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cut_i[k] |-> !cout_c[k]);
    end
    // A byte fenced on both sides is its own 8-bit lane with cin at its base
    assert_isolated_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_edge && hi_edge) |->
        ({cout_c[k], sum_c[k*SEG_W +: SEG_W]} ==
         ({1'b0, a_i[k*SEG_W +: SEG_W]} + {1'b0, b_i[k*SEG_W +: SEG_W]} +
          {{SEG_W{1'b0}}, cin_i})));
  end
endmodule

// File: tb/sim_simd_split_adder.sv
module sim_simd_split_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [2:0]  cut_i = '0;
  logic        cin_i = 1'b0;
  logic [31:0] sum_o;
  logic [3:0]  cout_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] sum;
    logic [3:0]  cout;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  simd_split_adder u0 (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i),
    .cut_i(cut_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o)
  );

  // Lane model: walk the mask, add each lane on its own in a wide integer
  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input logic [2:0] cut, input logic cin, input string tag);
    exp_t e;
    int lo;
    e.sum = '0; e.cout = '0; e.tag = tag;
    lo = 0;
    for (int hi = 0; hi < 4; hi++) begin
      if (hi == 3 || cut[hi]) begin
        longint unsigned w, msk, la, lb, r;
        w   = 64'(8 * (hi - lo + 1));
        msk = (64'd1 << w) - 64'd1;
        la  = (64'(a) >> (8 * lo)) & msk;
        lb  = (64'(b) >> (8 * lo)) & msk;
        r   = la + lb + 64'(cin);
        for (int bi = 0; bi < 8 * (hi - lo + 1); bi++)
          e.sum[8 * lo + bi] = r[bi];
        e.cout[hi] = r[w];
        lo = hi + 1;
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] cut, input logic cin, input string tag);
    @(negedge clk);
    a_i = a; b_i = b; cut_i = cut; cin_i = cin;
    sb_q.push_back(model(a, b, cut, cin, tag));
  endtask

  // Monitor: the result for inputs set at a falling edge is due after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        vectors++;
        if (sum_o !== e.sum || cout_o !== e.cout) begin
          miscompares++;
          $display("FAIL %s: sum=%h cout=%b expected sum=%h cout=%b",
                   e.tag, sum_o, cout_o, e.sum, e.cout);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R7: outputs held at zero while reset is low
    a_i = 32'hFFFF_FFFF; b_i = 32'h0000_0001; cin_i = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    vectors++;
    if (sum_o !== '0 || cout_o !== '0) begin
      miscompares++;
      $display("FAIL R7 reset: sum=%h cout=%b expected sum=0 cout=0", sum_o, cout_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: whole-word carry ripples to the top
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b000, 1'b0, "R1 full ripple");
    drive(32'h8000_0000, 32'h8000_0000, 3'b000, 1'b1, "R1 top carry");
    // R3: four bytes each overflowing, nothing leaks upward
    drive(32'hFFFF_FFFF, 32'h0101_0101, 3'b111, 1'b0, "R3 isolated bytes");
    drive(32'h00FF_00FF, 32'h0001_0001, 3'b010, 1'b0, "R2 two halves");
    // R4: carry-in enters every lane
    drive(32'hFFFF_FFFF, 32'h0000_0000, 3'b111, 1'b1, "R4 cin per byte");
    drive(32'h0000_FFFF, 32'h0000_0000, 3'b010, 1'b1, "R4 cin per half");
    // R5 / R6: mixed layouts
    drive(32'hFFFF_FFFF, 32'h0000_0101, 3'b001, 1'b0, "R6 8 under 24");
    drive(32'hFF00_FFFF, 32'h0100_0001, 3'b100, 1'b0, "R6 24 under 8");
    drive(32'h00FF_FFFF, 32'h0000_0001, 3'b000, 1'b0, "R5 inner cout zero");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b011, 1'b1, "R6 mixed 011");
    drive(32'hFFFF_FFFF, 32'h0001_0001, 3'b101, 1'b0, "R6 mixed 101");
    drive(32'hFFFF_FFFF, 32'h0100_0100, 3'b110, 1'b1, "R6 mixed 110");
    // R2: every layout with random operands
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 40; n++) begin
        drive($urandom, $urandom, 3'(m), 1'($urandom), "R2 random lanes");
      end
    end
    @(negedge clk);
    a_i = '0; b_i = '0;
    repeat (3) @(posedge clk);
    #3;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule